// File: doc/BRIEF.md
# Chained Command Prefetch Controller

This block manages the command-word pipeline of an I/O channel that walks a chained channel program held in memory. Each program entry is a pair of words: a command word, then an address word. The active pair sits in an active command register and an active address register. A second pair of registers, the shadow pair, receives the next entry ahead of time. The controller reads memory one word at a time over a request/grant port.

While the active order is a chained Read or Write, the controller fetches the next pair into the shadow registers. It starts that fetch only when the data path is idle, so data movement keeps priority. When the active order terminates, on word-count rollover or on device end, the shadow pair becomes active on the same clock edge. No memory access is needed, and a chained successor immediately arms another prefetch. If no complete shadow pair is ready at termination, the controller falls back to an ordinary fetch. A fetch that is already partly done is kept and finished into the active registers. A program begins with a start pulse that carries the program's first address.

Top module: `chain_prefetch_ctrl`

## Requirements
- R1: After reset, `mem_req_o`, `act_valid_o` and `shadow_valid_o` are all 0.
- R2: A `start_i` pulse while idle loads the program counter from `start_pc_i` and fetches two words: first the command word at the counter, then the address word at the counter plus one. When the second word is granted, both land in the active registers and `act_valid_o` goes to 1 on that edge.
- R3: Once raised, `mem_req_o` stays high with `mem_addr_o` unchanged until `mem_gnt_i` is seen. Each granted word advances the program counter by one, so a pair advances it by two. The word is taken from `mem_rdata_i` in the grant cycle.
- R4: The command word's bits [DW-1:DW-2] hold the order: 00 control, 01 read, 10 write, 11 end. Bit [DW-3] is the chaining flag. A prefetch starts only when the active order is read or write with chaining set.
- R5: During a read order, a prefetch starts only in a cycle where every bit of `inbuf_empty_i` is 1.
- R6: During a write order, a prefetch starts only in a cycle where every bit of `outbuf_full_i` is 1.
- R7: A completed prefetch loads the shadow pair and sets `shadow_valid_o`, and leaves the active registers unchanged.
- R8: When `wc_rollover_i` or `dev_end_i` is seen while `shadow_valid_o` is 1, the shadow pair moves into the active registers on that edge. `shadow_valid_o` clears, `act_valid_o` stays 1, and no memory request follows in the next cycle.
- R9: When a pair activated from the shadow registers is itself a chained read or write, a new prefetch starts under the same rules as R4 to R6.
- R10: A termination with no valid shadow pair drops `act_valid_o` and performs an ordinary fetch into the active registers. A prefetch that is in flight continues from its current word. A termination in the same cycle as the final grant of a prefetch loads that pair directly into the active registers.
- R11: A termination while the active order is end (11) returns the controller to idle, with `act_valid_o` at 0 and no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a program (honoured while idle) |
| start_pc_i | input | PW | First program address |
| inbuf_empty_i | input | NBUF | Per-buffer empty flags, read direction |
| outbuf_full_i | input | NBUF | Per-buffer full flags, write direction |
| wc_rollover_i | input | 1 | Active order terminated by word-count rollover |
| dev_end_i | input | 1 | Active order terminated by device end |
| mem_req_o | output | 1 | Memory word read request |
| mem_addr_o | output | PW | Memory word address |
| mem_gnt_i | input | 1 | Grant; read data valid in the same cycle |
| mem_rdata_i | input | DW | Memory read data |
| act_valid_o | output | 1 | Active registers hold a running order |
| act_cmd_o | output | DW | Active command word |
| act_addr_o | output | DW | Active address word |
| shadow_valid_o | output | 1 | Shadow pair holds an unconsumed prefetch |

## Verification
The hardest case to reach is a termination that lands while a prefetch is in flight, and above all in the exact cycle its second word is granted. In that cycle the pair must bypass the shadow registers and go straight into the active ones. Random termination seldom hits that single cycle. One stimulus mode therefore keys termination to the bench's own view of the fetch phase and grants every request. Other modes hold the buffer flags permissive or blocking so that gated and ungated prefetch both occur often.

// File: rtl/chain_pkg.sv
package chain_pkg;
    typedef enum logic [1:0] {
        ORD_CTRL  = 2'b00,
        ORD_READ  = 2'b01,
        ORD_WRITE = 2'b10,
        ORD_END   = 2'b11
    } order_e;

    typedef enum logic [1:0] {
        CTL_IDLE,
        CTL_FETCH,
        CTL_RUN
    } ctl_e;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_CMD,
        SEQ_ADR
    } seq_e;
endpackage

// File: rtl/chain_word_fetch.sv
// Two-word memory sequencer: command word, then address word, one
// request/grant handshake per word. Owns the program counter.
module chain_word_fetch
    import chain_pkg::*;
#(
    parameter int DW = 16,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic          load_i,
    input  logic [PW-1:0] load_pc_i,
    input  logic          mem_gnt_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          mem_req_o,
    output logic [PW-1:0] mem_addr_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [DW-1:0] pair_cmd_o,
    output logic [DW-1:0] pair_adr_o
);
    typedef struct packed {
        seq_e          ph;
        logic [PW-1:0] pc;
        logic [DW-1:0] hold;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.ph)
            SEQ_IDLE: begin
                if (go_i) begin
                    if (load_i) s_d.pc = load_pc_i;
                    s_d.ph = SEQ_CMD;
                end
            end
            SEQ_CMD: begin
                if (mem_gnt_i) begin
                    s_d.hold = mem_rdata_i;
                    s_d.pc   = s_q.pc + 1'b1;
                    s_d.ph   = SEQ_ADR;
                end
            end
            SEQ_ADR: begin
                if (mem_gnt_i) begin
                    s_d.pc = s_q.pc + 1'b1;
                    s_d.ph = SEQ_IDLE;
                end
            end
            default: s_d.ph = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{ph: SEQ_IDLE, pc: '0, hold: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o     = (s_q.ph != SEQ_IDLE);
    assign mem_req_o  = busy_o;
    assign mem_addr_o = s_q.pc;
    assign done_o     = (s_q.ph == SEQ_ADR) && mem_gnt_i;
    assign pair_cmd_o = s_q.hold;
    assign pair_adr_o = mem_rdata_i;
endmodule

// File: rtl/chain_gate.sv
// Decodes the active order field and decides whether the data path is
// idle enough for a prefetch to begin.
module chain_gate
    import chain_pkg::*;
#(
    parameter int NBUF = 2
) (
    input  logic [2:0]      ctl_bits_i,
    input  logic [NBUF-1:0] inbuf_empty_i,
    input  logic [NBUF-1:0] outbuf_full_i,
    output logic            chained_o,
    output logic            room_o,
    output logic            is_end_o
);
    order_e ord;
    logic   chain_flag;

    assign ord        = order_e'(ctl_bits_i[2:1]);
    assign chain_flag = ctl_bits_i[0];

    always_comb begin
        chained_o = 1'b0;
        room_o    = 1'b0;
        is_end_o  = 1'b0;
        unique case (ord)
            ORD_READ: begin
                chained_o = chain_flag;
                room_o    = &inbuf_empty_i;
            end
            ORD_WRITE: begin
                chained_o = chain_flag;
                room_o    = &outbuf_full_i;
            end
            ORD_END:  is_end_o = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/chain_prefetch_ctrl.sv
module chain_prefetch_ctrl
    import chain_pkg::*;
#(
    parameter int DW   = 16,
    parameter int PW   = 16,
    parameter int NBUF = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [PW-1:0]   start_pc_i,
    input  logic [NBUF-1:0] inbuf_empty_i,
    input  logic [NBUF-1:0] outbuf_full_i,
    input  logic            wc_rollover_i,
    input  logic            dev_end_i,
    output logic            mem_req_o,
    output logic [PW-1:0]   mem_addr_o,
    input  logic            mem_gnt_i,
    input  logic [DW-1:0]   mem_rdata_i,
    output logic            act_valid_o,
    output logic [DW-1:0]   act_cmd_o,
    output logic [DW-1:0]   act_addr_o,
    output logic            shadow_valid_o
);
    localparam int CTL_MSB = DW - 1;

    typedef struct packed {
        ctl_e          st;
        logic [DW-1:0] act_cmd;
        logic [DW-1:0] act_adr;
        logic [DW-1:0] sh_cmd;
        logic [DW-1:0] sh_adr;
        logic          sh_v;
    } ctl_t;

    ctl_t c_d, c_q;

    logic          go, load, busy, done;
    logic [DW-1:0] pair_cmd, pair_adr;
    logic          chained, room, is_end, term;

    chain_word_fetch #(.DW(DW), .PW(PW)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (go),
        .load_i     (load),
        .load_pc_i  (start_pc_i),
        .mem_gnt_i  (mem_gnt_i),
        .mem_rdata_i(mem_rdata_i),
        .mem_req_o  (mem_req_o),
        .mem_addr_o (mem_addr_o),
        .busy_o     (busy),
        .done_o     (done),
        .pair_cmd_o (pair_cmd),
        .pair_adr_o (pair_adr)
    );

    chain_gate #(.NBUF(NBUF)) u_gate (
        .ctl_bits_i   (c_q.act_cmd[CTL_MSB -: 3]),
        .inbuf_empty_i(inbuf_empty_i),
        .outbuf_full_i(outbuf_full_i),
        .chained_o    (chained),
        .room_o       (room),
        .is_end_o     (is_end)
    );

    assign term = wc_rollover_i | dev_end_i;

    always_comb begin
        c_d  = c_q;
        go   = 1'b0;
        load = 1'b0;
        unique case (c_q.st)
            CTL_IDLE: begin
                if (start_i) begin
                    go     = 1'b1;
                    load   = 1'b1;
                    c_d.st = CTL_FETCH;
                end
            end
            CTL_FETCH: begin
                if (done) begin
                    c_d.act_cmd = pair_cmd;
                    c_d.act_adr = pair_adr;
                    c_d.sh_v    = 1'b0;
                    c_d.st      = CTL_RUN;
                end
            end
            CTL_RUN: begin
                if (term) begin
                    if (is_end) begin
                        c_d.st = CTL_IDLE;
                    end else if (c_q.sh_v) begin
                        c_d.act_cmd = c_q.sh_cmd;
                        c_d.act_adr = c_q.sh_adr;
                        c_d.sh_v    = 1'b0;
                    end else if (done) begin
                        c_d.act_cmd = pair_cmd;
                        c_d.act_adr = pair_adr;
                    end else begin
                        c_d.st = CTL_FETCH;
                        go     = !busy;
                    end
                end else begin
                    if (done) begin
                        c_d.sh_cmd = pair_cmd;
                        c_d.sh_adr = pair_adr;
                        c_d.sh_v   = 1'b1;
                    end
                    go = chained && room && !busy && !c_q.sh_v;
                end
            end
            default: c_d.st = CTL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{st: CTL_IDLE, act_cmd: '0, act_adr: '0,
                     sh_cmd: '0, sh_adr: '0, sh_v: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign act_valid_o    = (c_q.st == CTL_RUN);
    assign act_cmd_o      = c_q.act_cmd;
    assign act_addr_o     = c_q.act_adr;
    assign shadow_valid_o = c_q.sh_v;
endmodule

// File: rtl/chain_prefetch_chk.sv
module chain_prefetch_chk #(
    parameter int PW   = 16,
    parameter int NBUF = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NBUF-1:0] inbuf_empty_i,
    input logic [NBUF-1:0] outbuf_full_i,
    input logic            wc_rollover_i,
    input logic            dev_end_i,
    input logic            mem_req_o,
    input logic [PW-1:0]   mem_addr_o,
    input logic            mem_gnt_i,
    input logic            act_valid_o,
    input logic [2:0]      ctl_bits_i,
    input logic            shadow_valid_o
);
    logic term, rw_chain, is_rd, is_wr, is_end;
    assign term     = wc_rollover_i | dev_end_i;
    assign is_rd    = (ctl_bits_i[2:1] == 2'b01);
    assign is_wr    = (ctl_bits_i[2:1] == 2'b10);
    assign is_end   = (ctl_bits_i[2:1] == 2'b11);
    assign rw_chain = (is_rd || is_wr) && ctl_bits_i[0];

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o));

    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_gnt_i |=> !mem_req_o || (mem_addr_o == $past(mem_addr_o) + 1'b1));

    p_no_pf_unchained_r4: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid_o && !mem_req_o && !rw_chain |=> !(act_valid_o && mem_req_o));

    p_read_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid_o && !mem_req_o && is_rd && !(&inbuf_empty_i) |=> !(act_valid_o && mem_req_o));

    p_write_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid_o && !mem_req_o && is_wr && !(&outbuf_full_i) |=> !(act_valid_o && mem_req_o));

    p_shadow_from_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !shadow_valid_o && !(mem_req_o && mem_gnt_i) |=> !shadow_valid_o);

    p_shadow_in_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_valid_o |-> act_valid_o);

    p_swap_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid_o && shadow_valid_o && term && !is_end |=> act_valid_o && !shadow_valid_o && !mem_req_o);

    p_end_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid_o && is_end && term |=> !act_valid_o && !mem_req_o);
endmodule

bind chain_prefetch_ctrl chain_prefetch_chk #(.PW(PW), .NBUF(NBUF)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .inbuf_empty_i (inbuf_empty_i),
    .outbuf_full_i (outbuf_full_i),
    .wc_rollover_i (wc_rollover_i),
    .dev_end_i     (dev_end_i),
    .mem_req_o     (mem_req_o),
    .mem_addr_o    (mem_addr_o),
    .mem_gnt_i     (mem_gnt_i),
    .act_valid_o   (act_valid_o),
    .ctl_bits_i    (act_cmd_o[DW-1 -: 3]),
    .shadow_valid_o(shadow_valid_o)
);

// File: tb/tb_chain_prefetch_ctrl.sv
`timescale 1ns/1ps
module tb_chain_prefetch_ctrl;
    localparam int DW = 16, PW = 16, NBUF = 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic            rst_n = 1'b0, start = 1'b0;
    logic [PW-1:0]   start_pc = '0;
    logic [NBUF-1:0] ine = '0, outf = '0;
    logic            wcr = 1'b0, dve = 1'b0, gnt = 1'b0;
    logic            mem_req, act_valid, shadow_valid;
    logic [PW-1:0]   mem_addr;
    logic [DW-1:0]   mem_rdata, act_cmd, act_addr;
    logic [DW-1:0]   mem [64];

    assign mem_rdata = mem[mem_addr[5:0]];

    chain_prefetch_ctrl #(.DW(DW), .PW(PW), .NBUF(NBUF)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .start_pc_i(start_pc),
        .inbuf_empty_i(ine), .outbuf_full_i(outf),
        .wc_rollover_i(wcr), .dev_end_i(dve),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr),
        .mem_gnt_i(gnt), .mem_rdata_i(mem_rdata),
        .act_valid_o(act_valid), .act_cmd_o(act_cmd), .act_addr_o(act_addr),
        .shadow_valid_o(shadow_valid)
    );

    int checks = 0, errors = 0;

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    function automatic bit rw_chain(logic [DW-1:0] c);
        return (c[DW-1:DW-2] == 2'b01 || c[DW-1:DW-2] == 2'b10) && c[DW-3];
    endfunction

    function automatic bit has_room(logic [DW-1:0] c, logic [NBUF-1:0] e, logic [NBUF-1:0] f);
        if (c[DW-1:DW-2] == 2'b01) return &e;
        if (c[DW-1:DW-2] == 2'b10) return &f;
        return 1'b0;
    endfunction

    // Reference model built from the requirements
    int            m_st = 0, m_ph = 0;   // st: 0 idle, 1 fetch, 2 run; ph: 0 idle, 1 cmd, 2 addr
    logic [PW-1:0] m_pc = '0;
    logic [DW-1:0] m_hold = '0, m_ac = '0, m_aa = '0, m_sc = '0, m_sa = '0, m_rd;
    bit            m_sv = 0, m_after_swap = 0, m_go, m_ld, m_done, m_term, m_swap;
    string         m_tag = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_ph = 0; m_pc = '0; m_hold = '0; m_ac = '0; m_aa = '0;
            m_sc = '0; m_sa = '0; m_sv = 0; m_after_swap = 0; m_tag = "R1";
        end else begin
            m_rd   = mem[m_pc[5:0]];
            m_done = (m_ph == 2) && gnt;
            m_term = wcr || dve;
            m_go = 0; m_ld = 0; m_swap = 0;
            m_tag  = (m_ph != 0 && !gnt) ? "R3" : "R2";
            case (m_st)
                0: if (start) begin m_go = 1; m_ld = 1; m_st = 1; end
                1: if (m_done) begin m_ac = m_hold; m_aa = m_rd; m_sv = 0; m_st = 2; end
                default: begin
                    if (m_term) begin
                        if (m_ac[DW-1:DW-2] == 2'b11) begin m_st = 0; m_tag = "R11"; end
                        else if (m_sv) begin m_ac = m_sc; m_aa = m_sa; m_sv = 0; m_swap = 1; m_tag = "R8"; end
                        else if (m_done) begin m_ac = m_hold; m_aa = m_rd; m_tag = "R10"; end
                        else begin m_st = 1; m_go = (m_ph == 0); m_tag = "R10"; end
                    end else begin
                        if (m_done) begin m_sc = m_hold; m_sa = m_rd; m_sv = 1; m_tag = "R7"; end
                        if (m_ph == 0 && !m_sv) begin
                            if (!rw_chain(m_ac)) m_tag = "R4";
                            else if (has_room(m_ac, ine, outf)) begin
                                m_go = 1; m_tag = m_after_swap ? "R9" : "R4";
                            end else m_tag = (m_ac[DW-1:DW-2] == 2'b01) ? "R5" : "R6";
                        end
                    end
                end
            endcase
            if (m_go && m_ph == 0) begin
                if (m_ld) m_pc = start_pc;
                m_ph = 1;
            end else if (m_ph == 1 && gnt) begin
                m_hold = m_rd; m_pc = m_pc + 1'b1; m_ph = 2;
            end else if (m_ph == 2 && gnt) begin
                m_pc = m_pc + 1'b1; m_ph = 0;
            end
            m_after_swap = m_swap;
        end
    end

    task automatic compare();
        chk(m_tag, "mem_req", 32'(mem_req), 32'(m_ph != 0));
        if (m_ph != 0) chk(m_tag, "mem_addr", 32'(mem_addr), 32'(m_pc));
        chk(m_tag, "act_valid", 32'(act_valid), 32'(m_st == 2));
        if (m_st == 2) begin
            chk(m_tag, "act_cmd", 32'(act_cmd), 32'(m_ac));
            chk(m_tag, "act_addr", 32'(act_addr), 32'(m_aa));
        end
        chk(m_tag, "shadow_valid", 32'(shadow_valid), 32'(m_sv));
    endtask

    task automatic fill_mem();
        for (int i = 0; i < 64; i++) begin
            logic [31:0] r = $urandom;
            logic [1:0]  ord;
            if (i % 2 == 1) mem[i] = r[DW-1:0];
            else begin
                case (r[2:0])
                    3'd0:             ord = 2'b11;
                    3'd1:             ord = 2'b00;
                    3'd2, 3'd3, 3'd4: ord = 2'b01;
                    default:          ord = 2'b10;
                endcase
                mem[i] = {ord, (r[4:3] != 2'b00), r[20:8]};
            end
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd4711);
        for (int ep = 0; ep < 60; ep++) begin
            int kind = ep % 5;
            fill_mem();
            @(negedge clk);
            rst_n = 0; start = 0; wcr = 0; dve = 0; gnt = 0;
            repeat (3) @(negedge clk);
            // R1: reset state
            chk("R1", "mem_req", 32'(mem_req), 0);
            chk("R1", "act_valid", 32'(act_valid), 0);
            chk("R1", "shadow_valid", 32'(shadow_valid), 0);
            rst_n = 1;
            start_pc = PW'({$urandom_range(0, 31), 1'b0});
            start = 1;
            @(negedge clk);
            start = 0;
            for (int cyc = 0; cyc < 400; cyc++) begin
                compare();
                if (m_st == 0) break;
                case (kind)
                    1: begin ine = '1; outf = '1; end
                    2: begin ine = '0; outf = '0; end
                    default: begin ine = NBUF'($urandom); outf = NBUF'($urandom); end
                endcase
                if (kind == 4) begin
                    gnt = 1;
                    wcr = (m_st == 2) && (m_ph == 2 || m_sv || m_ph == 1 && cyc % 3 == 0);
                    dve = 0;
                end else begin
                    gnt = ($urandom_range(0, 2) != 0);
                    wcr = (m_st == 2) && ($urandom_range(0, 13) == 0);
                    dve = (m_st == 2) && ($urandom_range(0, 13) == 0);
                end
                @(negedge clk);
            end
            wcr = 0; dve = 0;
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule